// File: doc/BRIEF.md
# Crosspoint Array Test Configuration Sequencer

This block walks a fixed, fault-directed list of test setups for a square crosspoint array of K horizontal and K vertical wires. Each step is one registered bundle. The bundle holds the configuration number, the sub-step index, a K*K programming mask, the drive levels for the horizontal and vertical wires, the fault-free output vector, and which architecture pair and which half of that pair apply. An external scorer reads the bundle, runs the test, and asks for the following step with a single-cycle `next_req`.

The list has five fixed setups:

- uniform high
- uniform low
- horizontal-neighbour bridging
- vertical-neighbour bridging
- reverse-biased crosspoint

A forward-biased crosspoint family follows them. That family programs one crosspoint per wire along a diagonal and moves the diagonal one column right at each sub-step.

Every setup is issued twice: first in the primary arrangement, then in its complementary arrangement. An optimized mode covers only the crosspoints that an AND/OR mapping needs. In that mode the reverse-bias setup programs a thin L shape, and the final diagonal shift is dropped. After the last step the sequencer drops `step_valid` and raises `seq_done`.

Top module: `xbar_test_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `step_valid`, `seq_done`, `cfg_id`, `xp_mask`, `h_drive`, `v_drive`, `expect_out`, `arch_sel` and `arch_phase` are all zero.
- R2: When `start` is high and `step_valid` is low, the next cycle shows `step_valid`=1, `cfg_id`=1, `sub_idx`=0, `arch_phase`=0. `seq_done` is cleared.
- R3: For `cfg_id`=1 (uniform high), every mask bit and every drive and expected bit is 1, and `arch_sel`=0. For `cfg_id`=2 (uniform low), every mask bit is 1, every drive and expected bit is 0, and `arch_sel`=1.
- R4: For `cfg_id`=3, the mask is full, `h_drive` has bit i set for even i, `v_drive` is all 1, `expect_out` equals `h_drive`, and `arch_sel`=0. For `cfg_id`=4, the mask is full, `h_drive` is all 0, `v_drive` has bit i set for even i, `expect_out` equals `v_drive`, and `arch_sel`=1.
- R5: For `cfg_id`=5, `h_drive` is all 1, `v_drive` is all 0, `expect_out` is all 1, and `arch_sel`=0. The mask is full in exhaustive mode. In optimized mode it holds only the bits of row 0 at columns 1..K-1 and of column 0 at rows 1..K-1, which is 2(K-1) bits. Mask bit r*K+c is the crosspoint of horizontal wire r and vertical wire c.
- R6: For `cfg_id`=6 with `sub_idx`=s, mask bit r*K+c is set exactly when c = (r+s) mod K. `v_drive` is all 1, `h_drive` and `expect_out` are all 0, and `arch_sel`=0. s runs over 0..K-1 in exhaustive mode and over 0..K-2 in optimized mode.
- R7: Each step is issued with `arch_phase`=0 and then, after one `next_req`, with `arch_phase`=1. All other fields stay the same between the two. Configurations run in the order 1..6.
- R8: While `step_valid` is high and `next_req` is low, the whole bundle stays unchanged.
- R9: A run issues 2K+10 steps in exhaustive mode and 2K+8 in optimized mode. The `next_req` that accepts the last step clears `step_valid` and sets `seq_done` on the following cycle. `seq_done` stays high until the next start.
- R10: `opt_mode` is sampled only on an accepted start. Changing it during a run has no effect on that run.
- R11: `start` while `step_valid` is high is ignored and leaves the bundle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| opt_mode | input | 1 | 1 selects the optimized list at start |
| next_req | input | 1 | Scorer accepts the current step |
| step_valid | output | 1 | A step bundle is presented |
| cfg_id | output | 3 | Configuration number 1..6, 0 when idle |
| sub_idx | output | SW | Diagonal shift index inside configuration 6 |
| xp_mask | output | K*K | Crosspoint programming mask, bit r*K+c |
| h_drive | output | K | Horizontal wire drive levels |
| v_drive | output | K | Vertical wire drive levels |
| expect_out | output | K | Fault-free output vector |
| arch_sel | output | 1 | Architecture pair: 0 first, 1 second |
| arch_phase | output | 1 | 0 primary arrangement, 1 complement |
| seq_done | output | 1 | Run completed |

## Verification
The hardest cases to reach are the ones where the sequencer must ignore its inputs partway through a run. These are a second `start` arriving while a step is presented, and `opt_mode` flipping after the run has latched it. The stimulus raises `start` in mid-run and flips `opt_mode` early in an exhaustive run. The bench then holds the scorer idle for extra cycles and checks that every later bundle still matches the list built for the latched mode. It also checks that the step count is still 2K+10.

// File: rtl/xts_pkg.sv
package xts_pkg;
  typedef enum logic [2:0] {
    CFG_IDLE    = 3'd0,
    CFG_UNIF_HI = 3'd1,
    CFG_UNIF_LO = 3'd2,
    CFG_BR_H    = 3'd3,
    CFG_BR_V    = 3'd4,
    CFG_XP_REV  = 3'd5,
    CFG_XP_FWD  = 3'd6
  } cfg_e;
endpackage

// File: rtl/xts_step_ctrl.sv
module xts_step_ctrl
  import xts_pkg::*;
#(
  parameter int K  = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          opt_mode,
  input  logic          next_req,
  output logic          nx_busy,
  output logic          nx_done,
  output cfg_e          nx_cfg,
  output logic [SW-1:0] nx_sub,
  output logic          nx_phase,
  output logic          nx_opt
);
  localparam logic [SW-1:0] LAST_FULL = SW'(K - 1);
  localparam logic [SW-1:0] LAST_OPT  = SW'(K - 2);

  logic          busy_q, done_q, phase_q, opt_q;
  cfg_e          cfg_q;
  logic [SW-1:0] sub_q;
  logic [SW-1:0] last_sub;

  assign last_sub = opt_q ? LAST_OPT : LAST_FULL;

  always_comb begin
    nx_busy  = busy_q;
    nx_done  = done_q;
    nx_cfg   = cfg_q;
    nx_sub   = sub_q;
    nx_phase = phase_q;
    nx_opt   = opt_q;
    if (!busy_q && start) begin
      nx_busy  = 1'b1;
      nx_done  = 1'b0;
      nx_cfg   = CFG_UNIF_HI;
      nx_sub   = '0;
      nx_phase = 1'b0;
      nx_opt   = opt_mode;
    end else if (busy_q && next_req) begin
      if (!phase_q) begin
        nx_phase = 1'b1;
      end else begin
        nx_phase = 1'b0;
        if (cfg_q == CFG_XP_FWD) begin
          if (sub_q == last_sub) begin
            nx_busy = 1'b0;
            nx_done = 1'b1;
            nx_cfg  = CFG_IDLE;
            nx_sub  = '0;
          end else begin
            nx_sub = sub_q + 1'b1;
          end
        end else begin
          nx_cfg = cfg_e'(3'(cfg_q + 3'd1));
          nx_sub = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= CFG_IDLE;
      sub_q   <= '0;
      phase_q <= 1'b0;
      opt_q   <= 1'b0;
    end else begin
      busy_q  <= nx_busy;
      done_q  <= nx_done;
      cfg_q   <= nx_cfg;
      sub_q   <= nx_sub;
      phase_q <= nx_phase;
      opt_q   <= nx_opt;
    end
  end
endmodule

// File: rtl/xts_pattern_gen.sv
module xts_pattern_gen
  import xts_pkg::*;
#(
  parameter int K  = 4,
  parameter int SW = 2
) (
  input  cfg_e            cfg,
  input  logic [SW-1:0]   sub,
  input  logic            opt,
  output logic [K*K-1:0]  mask,
  output logic [K-1:0]    h_lvl,
  output logic [K-1:0]    v_lvl,
  output logic [K-1:0]    exp_lvl,
  output logic            arch
);
  logic [K-1:0] alt;

  for (genvar i = 0; i < K; i++) begin : g_alt
    assign alt[i] = ((i % 2) == 0);
  end

  for (genvar r = 0; r < K; r++) begin : g_row
    logic [K-1:0] row_bits;
    always_comb begin
      row_bits = '0;
      for (int c = 0; c < K; c++) begin
        int tgt;
        tgt = r + int'(sub);
        if (tgt >= K) tgt = tgt - K;
        case (cfg)
          CFG_UNIF_HI, CFG_UNIF_LO, CFG_BR_H, CFG_BR_V:
            row_bits[c] = 1'b1;
          CFG_XP_REV:
            row_bits[c] = opt ? (((r == 0) && (c != 0)) || ((c == 0) && (r != 0)))
                              : 1'b1;
          CFG_XP_FWD:
            row_bits[c] = (c == tgt);
          default:
            row_bits[c] = 1'b0;
        endcase
      end
    end
    assign mask[r*K +: K] = row_bits;
  end

  always_comb begin
    h_lvl   = '0;
    v_lvl   = '0;
    exp_lvl = '0;
    arch    = 1'b0;
    case (cfg)
      CFG_UNIF_HI: begin
        h_lvl = '1; v_lvl = '1; exp_lvl = '1;
      end
      CFG_UNIF_LO: begin
        arch = 1'b1;
      end
      CFG_BR_H: begin
        h_lvl = alt; v_lvl = '1; exp_lvl = alt;
      end
      CFG_BR_V: begin
        v_lvl = alt; exp_lvl = alt; arch = 1'b1;
      end
      CFG_XP_REV: begin
        h_lvl = '1; exp_lvl = '1;
      end
      CFG_XP_FWD: begin
        v_lvl = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbar_test_seq.sv
module xbar_test_seq
  import xts_pkg::*;
#(
  parameter int K  = 4,
  parameter int SW = (K > 1) ? $clog2(K) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           opt_mode,
  input  logic           next_req,
  output logic           step_valid,
  output logic [2:0]     cfg_id,
  output logic [SW-1:0]  sub_idx,
  output logic [K*K-1:0] xp_mask,
  output logic [K-1:0]   h_drive,
  output logic [K-1:0]   v_drive,
  output logic [K-1:0]   expect_out,
  output logic           arch_sel,
  output logic           arch_phase,
  output logic           seq_done
);
  logic          nx_busy, nx_done, nx_phase, nx_opt;
  cfg_e          nx_cfg;
  logic [SW-1:0] nx_sub;
  logic [K*K-1:0] pg_mask;
  logic [K-1:0]  pg_h, pg_v, pg_exp;
  logic          pg_arch;

  xts_step_ctrl #(.K(K), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opt_mode(opt_mode),
    .next_req(next_req), .nx_busy(nx_busy), .nx_done(nx_done),
    .nx_cfg(nx_cfg), .nx_sub(nx_sub), .nx_phase(nx_phase), .nx_opt(nx_opt)
  );

  xts_pattern_gen #(.K(K), .SW(SW)) u_pat (
    .cfg(nx_cfg), .sub(nx_sub), .opt(nx_opt),
    .mask(pg_mask), .h_lvl(pg_h), .v_lvl(pg_v), .exp_lvl(pg_exp), .arch(pg_arch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_valid <= 1'b0;
      seq_done   <= 1'b0;
      cfg_id     <= '0;
      sub_idx    <= '0;
      xp_mask    <= '0;
      h_drive    <= '0;
      v_drive    <= '0;
      expect_out <= '0;
      arch_sel   <= 1'b0;
      arch_phase <= 1'b0;
    end else begin
      step_valid <= nx_busy;
      seq_done   <= nx_done;
      if (nx_busy) begin
        cfg_id     <= nx_cfg;
        sub_idx    <= nx_sub;
        xp_mask    <= pg_mask;
        h_drive    <= pg_h;
        v_drive    <= pg_v;
        expect_out <= pg_exp;
        arch_sel   <= pg_arch;
        arch_phase <= nx_phase;
      end else begin
        cfg_id     <= '0;
        sub_idx    <= '0;
        xp_mask    <= '0;
        h_drive    <= '0;
        v_drive    <= '0;
        expect_out <= '0;
        arch_sel   <= 1'b0;
        arch_phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xts_checker.sv
module xts_checker #(
  parameter int K  = 4,
  parameter int SW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           next_req,
  input logic           step_valid,
  input logic [2:0]     cfg_id,
  input logic [SW-1:0]  sub_idx,
  input logic [K*K-1:0] xp_mask,
  input logic           arch_phase,
  input logic           seq_done
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!step_valid && !seq_done && xp_mask == '0));

  p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !step_valid) |=> (step_valid && cfg_id == 3'd1 && sub_idx == '0 && !arch_phase && !seq_done));

  p_full_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (step_valid && cfg_id >= 3'd1 && cfg_id <= 3'd4) |-> (xp_mask == '1));

  p_diag_count_r6: assert property (@(posedge clk) disable iff (rst)
    (step_valid && cfg_id == 3'd6) |-> ($countones(xp_mask) == K));

  p_phase_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (step_valid && next_req && !arch_phase) |=>
      (step_valid && arch_phase && $stable(cfg_id) && $stable(sub_idx) && $stable(xp_mask)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !next_req) |=>
      (step_valid && $stable(cfg_id) && $stable(sub_idx) && $stable(xp_mask) && $stable(arch_phase)));

  p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(step_valid && seq_done));

  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (step_valid && start && !next_req) |=> ($stable(cfg_id) && $stable(arch_phase) && step_valid));
endmodule

bind xbar_test_seq xts_checker #(.K(K), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .next_req(next_req),
  .step_valid(step_valid), .cfg_id(cfg_id), .sub_idx(sub_idx),
  .xp_mask(xp_mask), .arch_phase(arch_phase), .seq_done(seq_done)
);

// File: tb/xbar_test_seq_tb.sv
module xbar_test_seq_tb;
  localparam int K  = 4;
  localparam int SW = $clog2(K);

  typedef struct packed {
    logic [2:0]     cfg;
    logic [SW-1:0]  sub;
    logic           ph;
    logic [K*K-1:0] mask;
    logic [K-1:0]   h;
    logic [K-1:0]   v;
    logic [K-1:0]   e;
    logic           arch;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, opt_mode = 1'b0, next_req = 1'b0;
  logic           step_valid, arch_sel, arch_phase, seq_done;
  logic [2:0]     cfg_id;
  logic [SW-1:0]  sub_idx;
  logic [K*K-1:0] xp_mask;
  logic [K-1:0]   h_drive, v_drive, expect_out;

  int checks = 0, errors = 0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  xbar_test_seq #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .start(start), .opt_mode(opt_mode), .next_req(next_req),
    .step_valid(step_valid), .cfg_id(cfg_id), .sub_idx(sub_idx), .xp_mask(xp_mask),
    .h_drive(h_drive), .v_drive(v_drive), .expect_out(expect_out),
    .arch_sel(arch_sel), .arch_phase(arch_phase), .seq_done(seq_done)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [K-1:0] even_bits();
    logic [K-1:0] b = '0;
    for (int i = 0; i < K; i += 2) b[i] = 1'b1;
    return b;
  endfunction

  function automatic item_t make_item(int cfg, int s, bit ph, bit opt);
    item_t it;
    it = '0;
    it.cfg = 3'(cfg); it.sub = SW'(s); it.ph = ph;
    it.mask = '1;
    case (cfg)
      1: begin it.h = '1; it.v = '1; it.e = '1; end
      2: it.arch = 1'b1;
      3: begin it.h = even_bits(); it.v = '1; it.e = even_bits(); end
      4: begin it.v = even_bits(); it.e = even_bits(); it.arch = 1'b1; end
      5: begin
        it.h = '1; it.e = '1;
        if (opt) begin
          it.mask = '0;
          for (int j = 1; j < K; j++) begin
            it.mask[j] = 1'b1;
            it.mask[j*K] = 1'b1;
          end
        end
      end
      default: begin
        it.v = '1;
        it.mask = '0;
        for (int r = 0; r < K; r++) it.mask[r*K + ((r + s) % K)] = 1'b1;
      end
    endcase
    return it;
  endfunction

  // driver side: push the expected step list for one run
  task automatic push_run(bit opt);
    for (int c = 1; c <= 5; c++)
      for (int p = 0; p < 2; p++) exp_q.push_back(make_item(c, 0, p[0], opt));
    for (int s = 0; s < (opt ? K-1 : K); s++)
      for (int p = 0; p < 2; p++) exp_q.push_back(make_item(6, s, p[0], opt));
  endtask

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic cmp_item(item_t it, string extra);
    item_t act;
    act = '{cfg_id, sub_idx, arch_phase, xp_mask, h_drive, v_drive, expect_out, arch_sel};
    chk(step_valid, {"R7 valid ", extra}, 64'(step_valid), 64'(1));
    chk(act.ph == it.ph, {"R7 phase ", extra}, 64'(act.ph), 64'(it.ph));
    chk(act == it, {tag_of(it.cfg), " bundle ", extra}, 64'(act), 64'(it));
  endtask

  // monitor side: pop and compare each step as presented
  task automatic run(bit opt, int exp_steps);
    int n = 0;
    push_run(opt);
    chk(exp_q.size() == exp_steps, "R9 list length", 64'(exp_q.size()), 64'(exp_steps));
    @(negedge clk); opt_mode = opt; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cfg_id == 3'd1 && !arch_phase && !seq_done, "R2 first step", 64'(cfg_id), 64'(1));
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      cmp_item(it, "");
      if (n == 1) opt_mode = ~opt;          // R10 flip mid-run
      if (n == 3) begin                     // R8 stall
        repeat (3) @(negedge clk);
        cmp_item(it, "R8 hold");
      end
      if (n == 7) begin                     // R11 start while busy
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        cmp_item(it, "R11 start ignored");
      end
      if (opt && it.cfg == 3'd5)
        chk($countones(xp_mask) == 2*(K-1), "R5 opt count",
            64'($countones(xp_mask)), 64'(2*(K-1)));
      next_req = 1'b1;
      @(negedge clk); next_req = 1'b0;
      n++;
    end
    chk(n == exp_steps, "R9 steps", 64'(n), 64'(exp_steps));
    chk(!step_valid && seq_done, "R9 done", 64'({step_valid, seq_done}), 64'(1));
    repeat (2) @(negedge clk);
    chk(!step_valid && seq_done, "R9 done held", 64'({step_valid, seq_done}), 64'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!step_valid && !seq_done && xp_mask == '0 && h_drive == '0 && expect_out == '0,
        "R1 in reset", 64'({step_valid, seq_done}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!step_valid && !seq_done && cfg_id == '0, "R1 after reset",
        64'({step_valid, seq_done, cfg_id}), 64'(0));
    run(1'b0, 2*K + 10);
    run(1'b1, 2*K + 8);
    run(1'b0, 2*K + 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule